// File: doc/BRIEF.md
# Prescaled Dual-Mode PWM Channel

This block is a single pulse-width channel that drives a continuous, repeating pulse train onto a pin through a tri-state buffer. A 16-bit divider turns the system clock into ticks. A frame counter then splits each period into an active phase and an idle phase. In fixed-frame mode the frame length is set by the resolution: 255 ticks at 8 bits or 65535 ticks at 16 bits, and the active phase lasts M ticks. In split mode the active phase lasts M ticks and the idle phase lasts N ticks, so the period follows M+N.

Software loads new divider and width values at any time with a commit pulse. These values sit in a shadow copy until the current frame ends, so a period is never cut short or stretched. When external triggering is selected, the channel stays off the pin until the trigger input first goes high. After that, a low trigger level freezes the waveform in place.

Top module: `pwm_chan`

## Requirements
- R1: After reset, and from the second clock edge after `en` is sampled low, `pwm_oe` is 0 and `pwm_out` is 0.
- R2: In split mode (`hl_mode`=1) the active level lasts (L+1)·M clock cycles and the idle level lasts (L+1)·N clock cycles, where L is `presc_val`, M is `hi_val` and N is `lo_val`. M=N=0 is not a legal setting.
- R3: In fixed-frame mode (`hl_mode`=0) the period is (L+1)·255 cycles when `res16`=0 and (L+1)·65535 cycles when `res16`=1, whatever M is. The active level lasts (L+1)·M cycles.
- R4: In fixed-frame mode, M=0 holds the output at the idle level and M=2^A−1 holds it at the active level, where A is 8 or 16.
- R5: In fixed-frame mode with `res16`=0, only bits [7:0] of `hi_val` set the active width.
- R6: The active level is 1 when `pol_hi`=1 and 0 when `pol_hi`=0. The idle level is the opposite value.
- R7: Values committed part-way through a period leave that period unchanged and apply from the next period on.
- R8: A commit sampled on the same edge as the frame wrap is applied at the wrap after that one. The period that follows the coincident wrap still uses the old values.
- R9: Starting the channel (`en` rising) restarts the divider and frame from zero in the active phase. The first enabled output cycle is active, and the first active phase is a full (L+1)·M cycles long. The starting values are those last committed before the start.
- R10: With `trig_en`=1 at start, `pwm_oe` stays 0 until `trig` is sampled high. It becomes 1 within two cycles after that.
- R11: With external triggering on, a low `trig` freezes the divider, the frame counter and the output. When `trig` returns high, counting resumes from the same point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel run enable; a rising level starts a fresh period |
| hl_mode | input | 1 | 0 = fixed-frame mode, 1 = split active/idle mode (captured at start) |
| res16 | input | 1 | Fixed-frame resolution: 0 = 255-tick frame, 1 = 65535-tick frame (captured at start) |
| pol_hi | input | 1 | Active-phase level on the pin (captured at start) |
| trig_en | input | 1 | Use `trig` to gate the channel (captured at start) |
| trig | input | 1 | Level trigger / run gate |
| presc_val | input | 16 | Divider value L; a tick lasts L+1 clocks |
| hi_val | input | 16 | Active width M in ticks |
| lo_val | input | 16 | Idle width N in ticks (split mode) |
| commit | input | 1 | One-cycle strobe that copies the three values into the shadow copy |
| pwm_out | output | 1 | Registered pulse level |
| pwm_oe | output | 1 | Registered enable for the external tri-state driver |

## Verification
The assertions check on every cycle that the divider and the frame counter stay inside their limits (R2, R3). They also check that active values change only at a wrap (R7), that a low trigger freezes both counters (R11), that the output stays disabled before the first trigger (R10), and that the output turns off after a disable (R1). Only the bench's scenarios can show the waveform widths in cycles under each mode, resolution and polarity (R2 to R6). The same holds for the exact period in which a committed value first appears, both part-way through a period and on the wrap edge itself (R7, R8), and for resuming a paused phase with the correct remaining length (R11).

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  parameter int unsigned DW = 16;

  typedef struct packed {
    logic [DW-1:0] presc;
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } pwm_vals_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         tick,
  output logic [W-1:0] count
);
  assign tick = adv && (count == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (adv) begin
      count <= (count == limit) ? '0 : count + W'(1);
    end
  end
endmodule

// File: rtl/pwm_frame.sv
module pwm_frame #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         wrap,
  output logic [W-1:0] count
);
  assign wrap = tick && (count == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (tick) begin
      count <= wrap ? '0 : count + W'(1);
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      commit,
  input  pwm_vals_t vals_in,
  input  logic      load,
  input  logic      wrap,
  output pwm_vals_t act
);
  pwm_vals_t shadow;
  logic      pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      pending <= 1'b0;
      act     <= '0;
    end else begin
      if (commit) shadow <= vals_in;
      if (load || (wrap && pending)) act <= shadow;
      pending <= commit || (pending && !(wrap || load));
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hl_mode,
  input  logic          res16,
  input  logic          pol_hi,
  input  logic          trig_en,
  input  logic          trig,
  input  logic [DW-1:0] presc_val,
  input  logic [DW-1:0] hi_val,
  input  logic [DW-1:0] lo_val,
  input  logic          commit,
  output logic          pwm_out,
  output logic          pwm_oe
);
  localparam int unsigned FW = DW + 1;
  localparam int unsigned SW = DW / 2;
  localparam logic [FW-1:0] LAST_WIDE   = FW'(2**DW - 2);
  localparam logic [FW-1:0] LAST_NARROW = FW'(2**SW - 2);

  logic run_q, seen_q, mode_q, res_q, pol_q, ext_q;
  logic start, adv, clr_cnt, tick, wrap, phase_act;
  logic [DW-1:0] pcnt, m_eff;
  logic [FW-1:0] fcnt, flast;
  pwm_vals_t vals_in, act;

  assign start   = en && !run_q;
  assign clr_cnt = !run_q;
  assign adv     = run_q && en && (!ext_q || trig);
  assign vals_in = '{presc: presc_val, hi: hi_val, lo: lo_val};

  // run control: configuration is latched on the start edge
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
      mode_q <= 1'b0;
      res_q  <= 1'b0;
      pol_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else if (!en) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      mode_q <= hl_mode;
      res_q  <= res16;
      pol_q  <= pol_hi;
      ext_q  <= trig_en;
      seen_q <= !trig_en || trig;
    end else begin
      seen_q <= seen_q || trig;
    end
  end

  pwm_shadow u_shadow (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .vals_in (vals_in),
    .load    (start),
    .wrap    (wrap),
    .act     (act)
  );

  pwm_prescaler #(.W(DW)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_cnt),
    .adv   (adv),
    .limit (act.presc),
    .tick  (tick),
    .count (pcnt)
  );

  always_comb begin
    if (mode_q) begin
      flast = {1'b0, act.hi} + {1'b0, act.lo} - FW'(1);
    end else begin
      flast = res_q ? LAST_WIDE : LAST_NARROW;
    end
  end

  pwm_frame #(.W(FW)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_cnt),
    .tick  (tick),
    .last  (flast),
    .wrap  (wrap),
    .count (fcnt)
  );

  always_comb begin
    if (mode_q || res_q) m_eff = act.hi;
    else                 m_eff = {{(DW-SW){1'b0}}, act.hi[SW-1:0]};
  end

  assign phase_act = fcnt < {1'b0, m_eff};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_oe  <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      pwm_oe  <= run_q && seen_q;
      pwm_out <= (run_q && seen_q) ? (phase_act ? pol_q : !pol_q) : 1'b0;
    end
  end
endmodule

// File: rtl/pwm_chan_sva.sv
module pwm_chan_sva
  import pwm_chan_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          trig,
  input logic          pwm_oe,
  input logic          run_q,
  input logic          seen_q,
  input logic          ext_q,
  input logic          wrap,
  input logic [DW-1:0] pcnt,
  input logic [DW:0]   fcnt,
  input logic [DW:0]   flast,
  input pwm_vals_t     act
);
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> ##1 !pwm_oe); // R1
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (pcnt <= act.presc)); // R2
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (fcnt <= flast)); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && !wrap) |=> $stable(act)); // R7
  AST_TRIG_WAIT: assert property (@(posedge clk) disable iff (rst)
    (run_q && !seen_q) |=> !pwm_oe); // R10
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && ext_q && !trig) |=> ($stable(fcnt) && $stable(pcnt))); // R11
endmodule

bind pwm_chan pwm_chan_sva u_sva (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .trig   (trig),
  .pwm_oe (pwm_oe),
  .run_q  (run_q),
  .seen_q (seen_q),
  .ext_q  (ext_q),
  .wrap   (wrap),
  .pcnt   (pcnt),
  .fcnt   (fcnt),
  .flast  (flast),
  .act    (act)
);

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;
  import pwm_chan_pkg::*;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, hl_mode = 1'b0, res16 = 1'b0;
  logic pol_hi = 1'b1, trig_en = 1'b0, trig = 1'b0, commit = 1'b0;
  logic [DW-1:0] presc_val = '0, hi_val = '0, lo_val = '0;
  logic pwm_out, pwm_oe;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  pwm_chan uut (
    .clk(clk), .rst(rst), .en(en), .hl_mode(hl_mode), .res16(res16),
    .pol_hi(pol_hi), .trig_en(trig_en), .trig(trig), .presc_val(presc_val),
    .hi_val(hi_val), .lo_val(lo_val), .commit(commit),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1: actual %0d cycles expected below 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_eq(input string req, input longint act_v, input longint exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int meff(int m, bit r16);
    return r16 ? m : (m & 255);
  endfunction
  function automatic int exp_fix_hi(int l, int m, bit r16);
    return (l + 1) * meff(m, r16);
  endfunction
  function automatic int exp_fix_lo(int l, int m, bit r16);
    return (l + 1) * ((r16 ? 65535 : 255) - meff(m, r16));
  endfunction

  task automatic setup(input bit hl, input bit r16, input bit pol, input bit ext,
                       input int l, input int m, input int n);
    en = 1'b0; step(); step();
    presc_val = DW'(l); hi_val = DW'(m); lo_val = DW'(n); commit = 1'b1;
    step();
    commit = 1'b0; hl_mode = hl; res16 = r16; pol_hi = pol; trig_en = ext; en = 1'b1;
    step();
    step();
  endtask

  task automatic wait_rise();
    int g = 0;
    while (pwm_out == pol_hi && g < 200000) begin step(); g++; end
    while (pwm_out != pol_hi && g < 200000) begin step(); g++; end
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (pwm_out == pol_hi && hi < 200000) begin hi++; step(); end
    while (pwm_out != pol_hi && lo < 200000) begin lo++; step(); end
  endtask

  initial begin
    int h, l, cnt;
    void'($urandom(32'h5eed1234));
    repeat (3) step();
    rst = 1'b0;
    step();
    check_eq("R1 reset oe", pwm_oe, 0);
    check_eq("R1 reset out", pwm_out, 0);

    // R9: start in active phase, full first width; R2 widths
    setup(1, 0, 1, 0, 1, 3, 2);
    check_eq("R9 first cycle active", pwm_out, 1);
    check_eq("R9 oe on", pwm_oe, 1);
    measure(h, l);
    check_eq("R9 first active width", h, 6);
    check_eq("R2 idle width", l, 4);
    measure(h, l);
    check_eq("R2 steady active width", h, 6);

    // R2/R6 random split-mode cases with random polarity
    for (int i = 0; i < 6; i++) begin
      int rl, rm, rn;
      bit rp;
      rl = $urandom_range(0, 3); rm = $urandom_range(1, 20);
      rn = $urandom_range(1, 20); rp = 1'($urandom_range(0, 1));
      setup(1, 0, rp, 0, rl, rm, rn);
      measure(h, l);
      check_eq("R6 R2 active width", h, (rl + 1) * rm);
      check_eq("R6 R2 idle width", l, (rl + 1) * rn);
    end

    // R3 random fixed-frame 8-bit
    for (int i = 0; i < 3; i++) begin
      int rl, rm;
      rl = $urandom_range(0, 1); rm = $urandom_range(1, 254);
      setup(0, 0, 1, 0, rl, rm, 0);
      measure(h, l);
      check_eq("R3 fixed active width", h, exp_fix_hi(rl, rm, 0));
      check_eq("R3 fixed idle width", l, exp_fix_lo(rl, rm, 0));
    end

    // R5: only low byte used at 8-bit
    setup(0, 0, 1, 0, 0, 16'h0105, 0);
    measure(h, l);
    check_eq("R5 low byte active", h, 5);
    check_eq("R5 low byte idle", l, 250);

    // R4/R6: M=0 constant idle with inverted polarity (idle level = 1)
    setup(0, 0, 0, 0, 0, 0, 0);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin if (pwm_out != 1'b1 || pwm_oe != 1'b1) cnt++; step(); end
    check_eq("R4 R6 M=0 constant idle", cnt, 0);
    setup(0, 0, 1, 0, 0, 255, 0);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin if (pwm_out != 1'b1) cnt++; step(); end
    check_eq("R4 M=full constant active", cnt, 0);

    // R3: 16-bit frame
    setup(0, 1, 1, 0, 0, 100, 0);
    measure(h, l);
    check_eq("R3 16-bit active", h, 100);
    check_eq("R3 16-bit idle", l, 65435);

    // R7: commit mid-period
    setup(1, 0, 1, 0, 0, 5, 5);
    wait_rise();
    h = 0;
    for (int i = 0; i < 3; i++) begin if (pwm_out == pol_hi) h++; step(); end
    hi_val = 16'd3; lo_val = 16'd4; commit = 1'b1;
    if (pwm_out == pol_hi) h++;
    step();
    commit = 1'b0;
    measure(cnt, l);
    check_eq("R7 current active unchanged", h + cnt, 5);
    check_eq("R7 current idle unchanged", l, 5);
    measure(h, l);
    check_eq("R7 next active new", h, 3);
    check_eq("R7 next idle new", l, 4);

    // R8: commit on the wrap edge
    setup(1, 0, 1, 0, 0, 5, 5);
    wait_rise();
    repeat (8) step();
    hi_val = 16'd2; lo_val = 16'd3; commit = 1'b1;
    step();
    commit = 1'b0;
    wait_rise();
    measure(h, l);
    check_eq("R8 period after coincident wrap old active", h, 5);
    check_eq("R8 period after coincident wrap old idle", l, 5);
    measure(h, l);
    check_eq("R8 following period new active", h, 2);
    check_eq("R8 following period new idle", l, 3);

    // R10: wait for trigger
    trig = 1'b0;
    setup(1, 0, 1, 1, 0, 20, 20);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin if (pwm_oe != 1'b0) cnt++; step(); end
    check_eq("R10 oe off before trigger", cnt, 0);
    trig = 1'b1;
    step(); step();
    check_eq("R10 oe on after trigger", pwm_oe, 1);

    // R11: pause and resume
    wait_rise();
    repeat (5) step();
    trig = 1'b0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); if (pwm_out != 1'b1 || pwm_oe != 1'b1) cnt++; end
    check_eq("R11 output held during pause", cnt, 0);
    trig = 1'b1;
    step();
    cnt = 0;
    while (pwm_out == 1'b1 && cnt < 1000) begin cnt++; step(); end
    check_eq("R11 remaining active after resume", cnt, 14);

    // R1: disable turns output off
    en = 1'b0;
    step(); step();
    check_eq("R1 disabled oe", pwm_oe, 0);
    check_eq("R1 disabled out", pwm_out, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule